// File: doc/BRIEF.md
# Fixed-Point DSP Arithmetic Unit with Sticky Status

This block is the 32-bit fixed-point arithmetic stage of a signal-processing datapath. On each valid strobe it takes two operands and an operation code. It can add, subtract, take the signed average, or apply a bitwise AND, OR or XOR. It registers the result together with four status flags: zero, negative, overflow and carry.

A second flag register runs beside the live flags. It ORs in every flag raised by an accepted operation and keeps those bits across any number of later operations. Only an explicit clear strobe empties it. Software can run a whole block of samples and then ask whether anything overflowed or carried out along the way.

A mode input selects how signed add and subtract handle overflow. With the mode off, the result wraps around. With the mode on, the result clamps to the largest positive or most negative 32-bit value.

Top module: `dsp_fxalu`

## Requirements
- R1: While reset is asserted and after it is released, before any operation is accepted, the result is 0 and both the live flags and the sticky flags are 0.
- R2: Operation code 0 (add) produces the 32-bit sum. The carry flag is the unsigned carry-out. The overflow flag is set when the signed sum does not fit in 32 bits. With saturation off, the result wraps around.
- R3: Operation code 1 (subtract) produces the first operand minus the second. The carry flag is 1 when no borrow occurs, which is when the first operand is at least the second as unsigned values. The overflow flag marks a signed overflow.
- R4: Operation code 2 (average) produces the floor of (A+B)/2, with both operands taken as signed. It never overflows, and it clears the overflow and carry flags.
- R5: Operation codes 3, 4 and 5 produce the bitwise AND, OR and XOR, and they clear the overflow and carry flags.
- R6: When the saturation input is 1 and an add or subtract overflows, the result is 0x7FFFFFFF if the true result is positive and 0x80000000 if it is negative. The overflow flag is still set. Results that do not overflow are unchanged.
- R7: The flag bits are: bit 0 zero, bit 1 negative, bit 2 overflow, bit 3 carry. Zero and negative describe the final result, after any saturation has been applied.
- R8: The result and the live flags change one clock after an accepted operation. An operation is accepted when the valid strobe is high and the operation code is between 0 and 5. At all other times they hold their values. Codes 6 and 7 are ignored.
- R9: The sticky flags become their previous value ORed with the flags of each accepted operation. An operation never clears a sticky bit.
- R10: A clear strobe empties the sticky flags on the next clock. If an operation is accepted in the same cycle as the clear, the sticky flags take that operation's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 3 | Operation code (0 add, 1 sub, 2 avg, 3 and, 4 or, 5 xor) |
| opValid | input | 1 | Accept the operation this cycle |
| satEn | input | 1 | Clamp signed add and subtract on overflow |
| stickyClr | input | 1 | Empty the sticky flags |
| result | output | 32 | Registered result |
| flags | output | 4 | Live flags: zero, negative, overflow, carry |
| stickyFlags | output | 4 | Accumulated flags |

## Verification
Add and subtract are driven with small values, with operands that cross the unsigned carry boundary, and with operands that push the signed sum past either extreme. Each of these is run with saturation off and with it on. This separates the wrapped result from the clamped one, and it separates carry from overflow. Average is tried at both extremes and with odd negative sums, which checks that it rounds toward minus infinity rather than toward zero. Idle cycles, the two reserved codes, and clears that coincide with a new operation then show that the result holds, and that the sticky register keeps or takes the right bits. A run of random operands and operations follows.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;
  localparam int FLAG_W = 4;
  localparam int FZ = 0;
  localparam int FN = 1;
  localparam int FV = 2;
  localparam int FC = 3;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AVG = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } aluOp_e;

  typedef struct packed {
    logic   load;
    logic   clrSticky;
    aluOp_e op;
  } aluCtl_t;
endpackage

// File: rtl/fxalu_ctrl.sv
module fxalu_ctrl
  import fxalu_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic       opValid,
  input  logic       stickyClr,
  output aluCtl_t    ctl
);
  logic legal;

  always_comb begin
    legal = (opSel <= 3'd5);
    ctl.load = opValid && legal;
    ctl.clrSticky = stickyClr;
    ctl.op = aluOp_e'(opSel);
  end
endmodule

// File: rtl/fxalu_dp.sv
module fxalu_dp
  import fxalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtl_t           ctl,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              satEn,
  output logic [W-1:0]      resQ,
  output logic [FLAG_W-1:0] flagQ,
  output logic [FLAG_W-1:0] stickyQ
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W:0]   ONE_EXT = {{W{1'b0}}, 1'b1};

  logic [W:0]          addFull;
  logic [W:0]          subFull;
  logic [W:0]          avgFull;
  logic                addOvf;
  logic                subOvf;
  logic [W-1:0]        resNew;
  logic                ovfNew;
  logic                carryNew;
  logic [FLAG_W-1:0]   flagNew;
  logic [FLAG_W-1:0]   stickyNext;

  always_comb begin
    addFull = {1'b0, a} + {1'b0, b};
    subFull = {1'b0, a} + {1'b0, ~b} + ONE_EXT;
    avgFull = {a[W-1], a} + {b[W-1], b};
    addOvf  = (a[W-1] == b[W-1]) && (addFull[W-1] != a[W-1]);
    subOvf  = (a[W-1] != b[W-1]) && (subFull[W-1] != a[W-1]);

    resNew   = '0;
    ovfNew   = 1'b0;
    carryNew = 1'b0;
    unique case (ctl.op)
      OP_ADD: begin
        ovfNew   = addOvf;
        carryNew = addFull[W];
        resNew   = (addOvf && satEn) ? (a[W-1] ? MAX_NEG : MAX_POS) : addFull[W-1:0];
      end
      OP_SUB: begin
        ovfNew   = subOvf;
        carryNew = subFull[W];
        resNew   = (subOvf && satEn) ? (a[W-1] ? MAX_NEG : MAX_POS) : subFull[W-1:0];
      end
      OP_AVG:  resNew = avgFull[W:1];
      OP_AND:  resNew = a & b;
      OP_OR:   resNew = a | b;
      OP_XOR:  resNew = a ^ b;
      default: resNew = '0;
    endcase

    flagNew     = '0;
    flagNew[FZ] = (resNew == '0);
    flagNew[FN] = resNew[W-1];
    flagNew[FV] = ovfNew;
    flagNew[FC] = carryNew;

    stickyNext = (ctl.clrSticky ? '0 : stickyQ) | (ctl.load ? flagNew : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ    <= '0;
      flagQ   <= '0;
      stickyQ <= '0;
    end else begin
      stickyQ <= stickyNext;
      if (ctl.load) begin
        resQ  <= resNew;
        flagQ <= flagNew;
      end
    end
  end
endmodule

// File: rtl/dsp_fxalu.sv
module dsp_fxalu
  import fxalu_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DataW-1:0]  opA,
  input  logic [DataW-1:0]  opB,
  input  logic [2:0]        opSel,
  input  logic              opValid,
  input  logic              satEn,
  input  logic              stickyClr,
  output logic [DataW-1:0]  result,
  output logic [3:0]        flags,
  output logic [3:0]        stickyFlags
);
  aluCtl_t ctl;

  fxalu_ctrl u_ctrl (
    .opSel     (opSel),
    .opValid   (opValid),
    .stickyClr (stickyClr),
    .ctl       (ctl)
  );

  fxalu_dp #(.W(DataW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .a       (opA),
    .b       (opB),
    .satEn   (satEn),
    .resQ    (result),
    .flagQ   (flags),
    .stickyQ (stickyFlags)
  );
endmodule

// File: rtl/fxalu_chk.sv
module fxalu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic [2:0]   opSel,
  input logic         opValid,
  input logic         satEn,
  input logic         stickyClr,
  input logic [W-1:0] result,
  input logic [3:0]   flags,
  input logic [3:0]   stickyFlags
);
  logic accepted;
  assign accepted = opValid && (opSel <= 3'd5);

  assert_sticky_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stickyClr |=> ((stickyFlags & $past(stickyFlags)) == $past(stickyFlags)));

  assert_sticky_covers_R10: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> ((flags & ~stickyFlags) == 4'b0000));

  assert_zero_neg_R7: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> ((flags[0] == (result == '0)) && (flags[1] == result[W-1])));

  assert_logic_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opSel >= 3'd3) |=> (flags[3:2] == 2'b00));

  assert_avg_no_ovf_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opSel == 3'd2) |=> !flags[2]);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> ($stable(result) && $stable(flags)));

  assert_clamp_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && satEn && opSel <= 3'd1) |=>
      (!flags[2] || result == {1'b0, {(W-1){1'b1}}} || result == {1'b1, {(W-1){1'b0}}}));
endmodule

bind dsp_fxalu fxalu_chk #(.W(DataW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opSel       (opSel),
  .opValid     (opValid),
  .satEn       (satEn),
  .stickyClr   (stickyClr),
  .result      (result),
  .flags       (flags),
  .stickyFlags (stickyFlags)
);

// File: tb/sim_dsp_fxalu.sv
module sim_dsp_fxalu;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] opA, opB;
  logic [2:0]  opSel;
  logic        opValid, satEn, stickyClr;
  logic [31:0] result;
  logic [3:0]  flags, stickyFlags;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] qRes[$];
  logic [3:0]  qFlg[$];
  logic [3:0]  qStk[$];
  string       qTag[$];

  logic [31:0] mRes = '0;
  logic [3:0]  mFlg = '0;
  logic [3:0]  mStk = '0;

  always #5 clk = ~clk;

  dsp_fxalu u0 (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .opValid(opValid), .satEn(satEn), .stickyClr(stickyClr),
    .result(result), .flags(flags), .stickyFlags(stickyFlags)
  );

  task automatic check(string tag, logic [31:0] r, logic [3:0] f, logic [3:0] s);
    nChecks++;
    if (result !== r || flags !== f || stickyFlags !== s) begin
      nFails++;
      $display("FAIL %s: got res=%h flg=%b stk=%b, expected res=%h flg=%b stk=%b",
               tag, result, flags, stickyFlags, r, f, s);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sat, output logic [31:0] r, output logic [3:0] f);
    longint sa, sb, full;
    logic ovf, cy;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ovf = 1'b0; cy = 1'b0; full = 0;
    case (op)
      3'd0: begin
        full = sa + sb;
        cy = (longint'(a) + longint'(b)) > 64'sh0FFFFFFFF;
      end
      3'd1: begin
        full = sa - sb;
        cy = (a >= b);
      end
      3'd2: full = (sa + sb) >>> 1;
      3'd3: full = longint'(a & b);
      3'd4: full = longint'(a | b);
      default: full = longint'(a ^ b);
    endcase
    if (op <= 3'd1) ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
    r = full[31:0];
    if (ovf && sat) r = (full > 0) ? 32'h7FFFFFFF : 32'h80000000;
    f = {cy, ovf, r[31], (r == 32'd0)};
  endtask

  task automatic drive(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                       logic v, logic sat, logic clr, string tag);
    logic [31:0] r;
    logic [3:0]  f;
    @(negedge clk);
    opSel = op; opA = a; opB = b; opValid = v; satEn = sat; stickyClr = clr;
    if (v && op <= 3'd5) begin
      model(op, a, b, sat, r, f);
      mStk = (clr ? 4'b0 : mStk) | f;
      mRes = r;
      mFlg = f;
    end else begin
      mStk = clr ? 4'b0 : mStk;
    end
    qRes.push_back(mRes); qFlg.push_back(mFlg); qStk.push_back(mStk); qTag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (qRes.size() > 0)
      check(qTag.pop_front(), qRes.pop_front(), qFlg.pop_front(), qStk.pop_front());
  end

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; opA = '0; opB = '0; opSel = '0; opValid = 0; satEn = 0; stickyClr = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'd0, 4'd0, 4'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'd0, 4'd0, 4'd0);

    drive(3'd0, 32'd5, 32'd7, 1, 0, 0, "R2 small add");
    drive(3'd0, 32'hFFFFFFFF, 32'd1, 1, 0, 0, "R2 R7 carry to zero");
    drive(3'd0, 32'h7FFFFFFF, 32'd1, 1, 0, 0, "R2 wrap overflow");
    drive(3'd0, 32'd9, 32'd9, 0, 0, 0, "R8 idle hold");
    drive(3'd6, 32'd1, 32'd2, 1, 0, 0, "R8 code 6 ignored");
    drive(3'd7, 32'd0, 32'd0, 1, 1, 0, "R8 code 7 ignored");
    drive(3'd0, 32'd1, 32'd1, 0, 0, 1, "R10 clear alone");
    drive(3'd1, 32'd3, 32'd5, 1, 0, 0, "R3 borrow negative");
    drive(3'd1, 32'd5, 32'd3, 1, 0, 0, "R3 no borrow");
    drive(3'd1, 32'h80000000, 32'd1, 1, 0, 0, "R3 signed overflow");
    drive(3'd1, 32'd7, 32'd7, 1, 0, 1, "R10 clear with op");
    drive(3'd0, 32'h7FFFFFFF, 32'd5, 1, 1, 0, "R6 clamp positive add");
    drive(3'd0, 32'h80000000, 32'h80000000, 1, 1, 0, "R6 clamp negative add");
    drive(3'd1, 32'h80000000, 32'd1, 1, 1, 0, "R6 clamp negative sub");
    drive(3'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 1, 1, 0, "R6 clamp positive sub");
    drive(3'd0, 32'd1, 32'd2, 1, 1, 1, "R6 no overflow unchanged");
    drive(3'd2, 32'h7FFFFFFF, 32'h7FFFFFFF, 1, 0, 0, "R4 avg max");
    drive(3'd2, 32'hFFFFFFFD, 32'd0, 1, 0, 0, "R4 avg floor");
    drive(3'd2, 32'h80000000, 32'h80000000, 1, 1, 0, "R4 avg min");
    drive(3'd3, 32'hF0F0F0F0, 32'h0F0F0F0F, 1, 0, 0, "R5 R7 and zero");
    drive(3'd4, 32'hF0000000, 32'h0000000F, 1, 0, 0, "R5 or");
    drive(3'd5, 32'hFFFF0000, 32'hFF00FF00, 1, 0, 0, "R5 xor");
    drive(3'd0, 32'd0, 32'd0, 0, 0, 0, "R9 sticky held");
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      drive(op, $urandom, $urandom, 1'($urandom), 1'($urandom), 1'(($urandom % 8) == 0),
            "R9 random mix");
    end
    drive(3'd0, 32'd0, 32'd0, 0, 0, 0, "R8 final idle");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule